// File: doc/BRIEF.md
# Hyperbolic CORDIC Unit

This block evaluates hyperbolic functions with shift-and-add micro-rotations that follow a hyperbola instead of a circle. It has two functions, chosen per sample by a one-bit select. In the first, a start vector on the real axis is moved along the hyperbola by an input hyperbolic angle, and the block returns the hyperbolic cosine and sine of that angle. In the second, an input vector is stepped along the hyperbola until its imaginary part reaches zero, and the block returns the accumulated angle, which is the inverse hyperbolic tangent of imag/real.

The datapath is fully unrolled and pipelined. It has one register stage per micro-rotation. A new sample can enter on every clock, and each result leaves a fixed number of cycles later with its valid flag. Shift indices start at 1, and the steps with shift 4, 13 and 40 run twice so that the iteration converges. The hyperbolic angle is a log-area quantity, so there is no quadrant folding. There is also no gain correction on the output: the start vector of the sinh/cosh function is preloaded with the reciprocal of the hyperbolic gain, so the results come out unscaled. Arithmetic works on internal guard bits, and the outputs are truncated toward minus infinity.

Top module: `hcordic_unit`

## Requirements
- R1: A sample presented with `in_valid` high on a rising edge gives exactly one result. `out_valid` is high exactly LAT rising edges later, where LAT is NUM_SHIFT plus one for each of the indices 4, 13 and 40 that is not above NUM_SHIFT. LAT is 18 for the defaults. A new sample is accepted on every cycle.
- R2: With `func_sel` = 0 (sinh/cosh), `out_real` is cosh(p) and `out_imag` is sinh(p) to within 6 LSB, for |p| <= 1.118. The angle p is `in_angle`/2^(PHASE_W-3), and the data values are two's complement with scale 2^(DATA_W-2).
- R3: With `func_sel` = 1 (arctanh), `out_angle`/2^(PHASE_W-3) is atanh(`in_imag`/`in_real`) to within 3 LSB, for `in_real` > 0 and |imag/real| <= 0.78. The data inputs use scale 2^(DATA_W-2).
- R4: Inputs that the selected function does not use have no effect on its results: `in_real` and `in_imag` in sinh/cosh mode, and `in_angle` in arctanh mode.
- R5: The output that a function does not produce is zero while `out_valid` is high. `out_angle` is 0 for a sinh/cosh result, and `out_real` and `out_imag` are 0 for an arctanh result.
- R6: While `out_valid` is low, `out_real`, `out_imag` and `out_angle` are all zero.
- R7: Synchronous active-high `rst` discards every sample in flight. `out_valid` is low on the cycle after reset is released and stays low until a sample accepted after reset reaches the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample valid |
| func_sel | input | 1 | 0 = sinh/cosh, 1 = arctanh |
| in_real | input | DATA_W | Real part of input vector (arctanh) |
| in_imag | input | DATA_W | Imaginary part of input vector (arctanh) |
| in_angle | input | PHASE_W | Hyperbolic angle (sinh/cosh) |
| out_valid | output | 1 | Result valid |
| out_real | output | DATA_W | cosh result |
| out_imag | output | DATA_W | sinh result |
| out_angle | output | PHASE_W | atanh result |

## Verification
The bench targets the extreme angles ±1.118. If the angle table were wrong or a repeated iteration were missing, the residual angle would not converge and cosh/sinh would be off by many LSB at those points. It runs arctanh on ratios near ±0.78 and on a zero imaginary part. A wrong direction rule in vectoring would make y diverge and give an angle of the wrong sign or size. It switches function on every cycle, which exposes a mode bit that does not travel with its data as wrong-format or non-zero unused outputs. A reset in the middle of a stream would let stale results appear if the valid pipeline were not cleared.

// File: rtl/hcordic_pkg.sv
package hcordic_pkg;

    typedef enum logic {
        MODE_SINHCOSH = 1'b0,
        MODE_ATANH    = 1'b1
    } mode_t;

    // Total micro-rotation count: indices 1..nshift with 4, 13, 40 doubled.
    function automatic int stage_total(input int nshift);
        int cnt;
        cnt = nshift;
        if (nshift >= 4)  cnt++;
        if (nshift >= 13) cnt++;
        if (nshift >= 40) cnt++;
        return cnt;
    endfunction

    // Shift index used by pipeline stage s (0-based).
    function automatic int shift_at(input int s, input int nshift);
        int idx;
        idx = 0;
        for (int i = 1; i <= nshift; i++) begin
            if (idx == s) return i;
            idx++;
            if (i == 4 || i == 13 || i == 40) begin
                if (idx == s) return i;
                idx++;
            end
        end
        return nshift;
    endfunction

    // atanh(2^-i) with frac fractional bits, from the odd power series.
    function automatic longint atanh_fix(input int i, input int frac);
        longint acc;
        int     f;
        f   = frac + 8;
        acc = 0;
        for (int k = 1; k < 64; k += 2) begin
            if (k * i <= f) acc += (longint'(1) << (f - k * i)) / k;
        end
        return (acc + (longint'(1) << 7)) >>> 8;
    endfunction

    // Reciprocal of the hyperbolic gain with frac fractional bits.
    function automatic longint inv_gain_fix(input int frac);
        real r;
        r = 1.2074970677630720;
        for (int k = 0; k < frac; k++) r = r * 2.0;
        return longint'(r);
    endfunction

endpackage

// File: rtl/hcordic_prep.sv
module hcordic_prep
    import hcordic_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int PHASE_W = 16,
    parameter int GUARD   = 4,
    localparam int XW = DATA_W + GUARD + 1,
    localparam int XF = DATA_W - 2 + GUARD,
    localparam int ZW = PHASE_W + GUARD
) (
    input  logic                      func_sel,
    input  logic [DATA_W-1:0]         in_real,
    input  logic [DATA_W-1:0]         in_imag,
    input  logic [PHASE_W-1:0]        in_angle,
    output mode_t                     mode,
    output logic signed [XW-1:0]      x0,
    output logic signed [XW-1:0]      y0,
    output logic signed [ZW-1:0]      z0
);

    localparam logic signed [XW-1:0] START_X = XW'(inv_gain_fix(XF));

    always_comb begin
        mode = func_sel ? MODE_ATANH : MODE_SINHCOSH;
        if (mode == MODE_ATANH) begin
            x0 = {in_real[DATA_W-1], in_real, {GUARD{1'b0}}};
            y0 = {in_imag[DATA_W-1], in_imag, {GUARD{1'b0}}};
            z0 = '0;
        end else begin
            x0 = START_X;
            y0 = '0;
            z0 = {in_angle, {GUARD{1'b0}}};
        end
    end

endmodule

// File: rtl/hcordic_stage.sv
module hcordic_stage
    import hcordic_pkg::*;
#(
    parameter int XW    = 21,
    parameter int ZW    = 20,
    parameter int SHIFT = 1,
    parameter logic signed [ZW-1:0] ANGLE = '0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  i_vld,
    input  mode_t                 i_mode,
    input  logic signed [XW-1:0]  i_x,
    input  logic signed [XW-1:0]  i_y,
    input  logic signed [ZW-1:0]  i_z,
    output logic                  o_vld,
    output mode_t                 o_mode,
    output logic signed [XW-1:0]  o_x,
    output logic signed [XW-1:0]  o_y,
    output logic signed [ZW-1:0]  o_z
);

    logic                 step_up;
    logic signed [XW-1:0] xs;
    logic signed [XW-1:0] ys;
    logic signed [XW-1:0] nx;
    logic signed [XW-1:0] ny;
    logic signed [ZW-1:0] nz;

    always_comb begin
        xs = i_x >>> SHIFT;
        ys = i_y >>> SHIFT;
        // rotation follows the sign of z, vectoring drives y toward zero
        step_up = (i_mode == MODE_ATANH) ? i_y[XW-1] : ~i_z[ZW-1];
        if (step_up) begin
            nx = i_x + ys;
            ny = i_y + xs;
            nz = i_z - ANGLE;
        end else begin
            nx = i_x - ys;
            ny = i_y - xs;
            nz = i_z + ANGLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) o_vld <= 1'b0;
        else     o_vld <= i_vld;
        o_mode <= i_mode;
        o_x    <= nx;
        o_y    <= ny;
        o_z    <= nz;
    end

endmodule

// File: rtl/hcordic_post.sv
module hcordic_post
    import hcordic_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int PHASE_W = 16,
    parameter int GUARD   = 4,
    localparam int XW = DATA_W + GUARD + 1,
    localparam int ZW = PHASE_W + GUARD
) (
    input  logic                  vld,
    input  mode_t                 mode,
    input  logic signed [XW-1:0]  x,
    input  logic signed [XW-1:0]  y,
    input  logic signed [ZW-1:0]  z,
    output logic [DATA_W-1:0]     out_real,
    output logic [DATA_W-1:0]     out_imag,
    output logic [PHASE_W-1:0]    out_angle
);

    logic unused_bits;
    assign unused_bits = ^{x[XW-1], y[XW-1], x[GUARD-1:0], y[GUARD-1:0], z[GUARD-1:0]};

    always_comb begin
        out_real  = '0;
        out_imag  = '0;
        out_angle = '0;
        if (vld) begin
            if (mode == MODE_ATANH) begin
                out_angle = z[ZW-1:GUARD];
            end else begin
                out_real = x[XW-2:GUARD];
                out_imag = y[XW-2:GUARD];
            end
        end
    end

endmodule

// File: rtl/hcordic_unit.sv
module hcordic_unit
    import hcordic_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int PHASE_W   = 16,
    parameter int GUARD     = 4,
    parameter int NUM_SHIFT = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic                func_sel,
    input  logic [DATA_W-1:0]   in_real,
    input  logic [DATA_W-1:0]   in_imag,
    input  logic [PHASE_W-1:0]  in_angle,
    output logic                out_valid,
    output logic [DATA_W-1:0]   out_real,
    output logic [DATA_W-1:0]   out_imag,
    output logic [PHASE_W-1:0]  out_angle
);

    localparam int XW  = DATA_W + GUARD + 1;
    localparam int ZW  = PHASE_W + GUARD;
    localparam int ZF  = PHASE_W - 3 + GUARD;
    localparam int NST = stage_total(NUM_SHIFT);

    logic                 vld  [0:NST];
    mode_t                mde  [0:NST];
    logic signed [XW-1:0] xs   [0:NST];
    logic signed [XW-1:0] ys   [0:NST];
    logic signed [ZW-1:0] zs   [0:NST];

    assign vld[0] = in_valid;

    hcordic_prep #(
        .DATA_W (DATA_W),
        .PHASE_W(PHASE_W),
        .GUARD  (GUARD)
    ) u_prep (
        .func_sel(func_sel),
        .in_real (in_real),
        .in_imag (in_imag),
        .in_angle(in_angle),
        .mode    (mde[0]),
        .x0      (xs[0]),
        .y0      (ys[0]),
        .z0      (zs[0])
    );

    for (genvar g = 0; g < NST; g++) begin : g_stage
        localparam int                   SH  = shift_at(g, NUM_SHIFT);
        localparam logic signed [ZW-1:0] ANG = ZW'(atanh_fix(SH, ZF));

        hcordic_stage #(
            .XW   (XW),
            .ZW   (ZW),
            .SHIFT(SH),
            .ANGLE(ANG)
        ) u_stage (
            .clk   (clk),
            .rst   (rst),
            .i_vld (vld[g]),
            .i_mode(mde[g]),
            .i_x   (xs[g]),
            .i_y   (ys[g]),
            .i_z   (zs[g]),
            .o_vld (vld[g+1]),
            .o_mode(mde[g+1]),
            .o_x   (xs[g+1]),
            .o_y   (ys[g+1]),
            .o_z   (zs[g+1])
        );
    end

    assign out_valid = vld[NST];

    hcordic_post #(
        .DATA_W (DATA_W),
        .PHASE_W(PHASE_W),
        .GUARD  (GUARD)
    ) u_post (
        .vld      (vld[NST]),
        .mode     (mde[NST]),
        .x        (xs[NST]),
        .y        (ys[NST]),
        .z        (zs[NST]),
        .out_real (out_real),
        .out_imag (out_imag),
        .out_angle(out_angle)
    );

endmodule

// File: rtl/hcordic_checker.sv
module hcordic_checker
    import hcordic_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int PHASE_W   = 16,
    parameter int NUM_SHIFT = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic                func_sel,
    input logic                out_valid,
    input logic [DATA_W-1:0]   out_real,
    input logic [DATA_W-1:0]   out_imag,
    input logic [PHASE_W-1:0]  out_angle
);

    localparam int LAT = stage_total(NUM_SHIFT);
    localparam int ONE = 1 << (DATA_W - 2);

    logic [LAT-1:0] v_hist;
    logic [LAT-1:0] m_hist;

    always_ff @(posedge clk) begin
        if (rst) v_hist <= '0;
        else     v_hist <= {v_hist[LAT-2:0], in_valid};
        m_hist <= {m_hist[LAT-2:0], func_sel};
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        out_valid == v_hist[LAT-1]);                                      // R1

    AST_COSH_AT_LEAST_ONE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !m_hist[LAT-1]) |-> ($signed(out_real) >= ONE - 8)); // R2

    AST_SC_ANGLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !m_hist[LAT-1]) |-> (out_angle == '0));              // R5

    AST_AT_DATA_ZERO: assert property (@(posedge clk) disable iff (rst)
        (out_valid && m_hist[LAT-1]) |-> (out_real == '0 && out_imag == '0)); // R5

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_real == '0 && out_imag == '0 && out_angle == '0)); // R6

    AST_RESET_FLUSH: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid);                                       // R7

endmodule

bind hcordic_unit hcordic_checker #(
    .DATA_W   (DATA_W),
    .PHASE_W  (PHASE_W),
    .NUM_SHIFT(NUM_SHIFT)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .func_sel (func_sel),
    .out_valid(out_valid),
    .out_real (out_real),
    .out_imag (out_imag),
    .out_angle(out_angle)
);

// File: tb/hcordic_unit_test.sv
`timescale 1ns/1ps
module hcordic_unit_test;

    localparam int  DW  = 16;
    localparam int  PW  = 16;
    localparam int  LAT = 18;          // 16 shifts + repeats of 4 and 13
    localparam real DS  = 16384.0;     // data scale 2^(DW-2)
    localparam real PS  = 8192.0;      // angle scale 2^(PW-3)
    localparam int  CAP = 4096;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          func_sel = 1'b0;
    logic [DW-1:0] in_real = '0;
    logic [DW-1:0] in_imag = '0;
    logic [PW-1:0] in_angle = '0;
    logic          out_valid;
    logic [DW-1:0] out_real;
    logic [DW-1:0] out_imag;
    logic [PW-1:0] out_angle;

    always #4 clk = ~clk;

    hcordic_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .func_sel(func_sel),
        .in_real(in_real), .in_imag(in_imag), .in_angle(in_angle),
        .out_valid(out_valid), .out_real(out_real), .out_imag(out_imag),
        .out_angle(out_angle)
    );

    int  total = 0;
    int  bad   = 0;
    int  cyc   = 0;
    bit  done  = 0;
    bit  hv [0:CAP-1];
    bit  hm [0:CAP-1];
    bit  hf [0:CAP-1];
    real ea [0:CAP-1];
    real eb [0:CAP-1];

    function automatic real f_cosh(input real p);
        return ($exp(p) + $exp(-p)) / 2.0;
    endfunction
    function automatic real f_sinh(input real p);
        return ($exp(p) - $exp(-p)) / 2.0;
    endfunction
    function automatic real f_atanh(input real t);
        return 0.5 * $ln((1.0 + t) / (1.0 - t));
    endfunction
    function automatic real absr(input real v);
        return (v < 0.0) ? -v : v;
    endfunction

    task automatic chk(input bit ok, input string tag, input real act, input real exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s cycle=%0d actual=%0.3f expected=%0.3f", tag, cyc, act, exp);
        end
    endtask

    task automatic check_out();
        int  idx;
        bit  ev;
        real ar, ai, aa;
        idx = cyc - LAT;
        ev  = (idx >= 1) ? hv[idx] : 1'b0;
        ar  = real'($signed(out_real));
        ai  = real'($signed(out_imag));
        aa  = real'($signed(out_angle));
        if (idx >= 1 && hf[idx])
            chk(out_valid == ev, "R7 flushed valid", real'(out_valid), real'(ev));
        else
            chk(out_valid == ev, "R1 valid latency", real'(out_valid), real'(ev));
        if (!out_valid) begin
            chk(out_real == 0 && out_imag == 0 && out_angle == 0, "R6 idle outputs",
                ar + ai + aa, 0.0);
        end else if (ev) begin
            if (!hm[idx]) begin
                chk(absr(ar - ea[idx] * DS) <= 6.0, "R2,R4 cosh", ar, ea[idx] * DS);
                chk(absr(ai - eb[idx] * DS) <= 6.0, "R2,R4 sinh", ai, eb[idx] * DS);
                chk(out_angle == 0, "R5 angle zero", aa, 0.0);
            end else begin
                chk(absr(aa - ea[idx] * PS) <= 3.0, "R3,R4 atanh", aa, ea[idx] * PS);
                chk(out_real == 0 && out_imag == 0, "R5 data zero", ar + ai, 0.0);
            end
        end
    endtask

    task automatic tick(input bit r, input bit v, input bit m,
                        input int re, input int im, input int an);
        @(negedge clk);
        cyc++;
        check_out();
        rst      = r;
        in_valid = v;
        func_sel = m;
        in_real  = DW'(re);
        in_imag  = DW'(im);
        in_angle = PW'(an);
        hf[cyc]  = 1'b0;
        if (r) begin
            for (int k = 0; k < LAT; k++) begin
                if (cyc - k >= 1) begin
                    if (hv[cyc - k]) hf[cyc - k] = 1'b1;
                    hv[cyc - k] = 1'b0;
                end
            end
            hv[cyc] = 1'b0;
        end else begin
            hv[cyc] = v;
            hm[cyc] = m;
            if (!m) begin
                ea[cyc] = f_cosh(real'(an) / PS);
                eb[cyc] = f_sinh(real'(an) / PS);
            end else begin
                ea[cyc] = f_atanh(real'(im) / real'(re));
                eb[cyc] = 0.0;
            end
        end
    endtask

    function automatic int rnd16();
        return int'($urandom_range(0, 65535)) - 32768;
    endfunction

    task automatic rnd_sample(input bit v, input bit m);
        int x, y, a;
        real fr;
        if (!m) begin
            a = int'($urandom_range(0, 18300)) - 9150;
            tick(1'b0, v, 1'b0, rnd16(), rnd16(), a);            // R4: unused data random
        end else begin
            x  = int'($urandom_range(8192, 32767));
            fr = (real'(int'($urandom_range(0, 1560))) - 780.0) / 1000.0;
            y  = $rtoi(real'(x) * fr);
            tick(1'b0, v, 1'b1, x, y, rnd16());                  // R4: unused angle random
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd5813));
        for (int i = 0; i < CAP; i++) begin
            hv[i] = 0; hm[i] = 0; hf[i] = 0; ea[i] = 0.0; eb[i] = 0.0;
        end
        // reset state (R1, R6 checked each cycle)
        for (int i = 0; i < 4; i++) tick(1'b1, 1'b0, 1'b0, 0, 0, 0);

        // directed corners, function alternating each cycle
        tick(1'b0, 1'b1, 1'b0, 12345, -777, 0);         // R2 zero angle
        tick(1'b0, 1'b1, 1'b1, 16384, 0, 5000);         // R3 zero imag
        tick(1'b0, 1'b1, 1'b0, -1, 999, 9158);          // R2 max angle
        tick(1'b0, 1'b1, 1'b1, 16384, -12779, -3000);   // R3 ratio -0.78
        tick(1'b0, 1'b1, 1'b0, 0, 0, -9158);            // R2 min angle
        tick(1'b0, 1'b1, 1'b1, 32767, 22937, 0);        // R3 large real
        tick(1'b0, 1'b1, 1'b0, 4, 4, 4096);
        tick(1'b0, 1'b1, 1'b1, 8192, 6389, 1);          // R3 small real, ratio 0.78
        tick(1'b0, 1'b1, 1'b0, 4, 4, -4096);
        for (int i = 0; i < LAT + 2; i++) tick(1'b0, 1'b0, 1'b0, 0, 0, 0);

        // random mix with gaps
        for (int i = 0; i < 1800; i++)
            rnd_sample($urandom_range(0, 3) != 0, 1'($urandom_range(0, 1)));

        // reset with samples in flight (R7)
        for (int i = 0; i < 10; i++) rnd_sample(1'b1, 1'($urandom_range(0, 1)));
        tick(1'b1, 1'b1, 1'b0, 0, 0, 100);
        tick(1'b1, 1'b1, 1'b1, 16384, 100, 0);
        for (int i = 0; i < LAT + 4; i++) tick(1'b0, 1'b0, 1'b0, 0, 0, 0);

        // back-to-back after reset
        for (int i = 0; i < 200; i++) rnd_sample(1'b1, 1'($urandom_range(0, 1)));
        for (int i = 0; i < LAT + 3; i++) tick(1'b0, 1'b0, 1'b0, 0, 0, 0);

        done = 1;
        finish_run();
    end

endmodule